// File: doc/BRIEF.md
# DRAM Bank Open/Idle Tracker with Precharge Issue

This block sits between a memory controller's request scheduler and the DRAM command pins. It remembers, for each bank, whether a row is open or the bank is idle, and whether the bank is still inside its row-precharge recovery window. Each cycle it takes at most one request (activate, read, write or precharge), decides whether it is legal, and drives the registered command and address pins one clock later. A request that is not legal becomes a NOP, and a one-cycle error pulse is raised instead.

A precharge closes either one bank or every bank. The choice is made by a single address bit, which is bit 10 by default. When the all-bank form is used, the bank address pins carry no meaning and are driven to zero. Every precharge starts a countdown for each bank it closes. A bank can be activated again only once its countdown has run out. Per-bank idle flags and a combined all-idle flag tell the scheduler when it may activate a bank or enter a low-power state.

Top module: `bank_state_tracker`

## Requirements
- R1: While reset is held, and on the first cycle after it, the pins show NOP (cs_n=0, ras_n=1, cas_n=1, we_n=1), with bank and address zero. req_err is 0, every bank_idle bit is 1 and all_idle is 1.
- R2: A cycle with no valid request drives NOP on the pins one clock later, with cmd_ba=0 and cmd_addr=0.
- R3: The request opcode is ACT=0, RD=1, WR=2, PRE=3. An ACT to a bank that is idle and has finished its countdown drives {cs_n,ras_n,cas_n,we_n}=0011 one clock later, with cmd_ba set to the bank and cmd_addr set to req_arg (the row). That bank's bank_idle bit then clears.
- R4: A RD to an open bank drives 0101, and a WR drives 0100. The column req_arg[COL_W-1:0] goes on the address bits other than bit ALL_BIT, from the low bits upward. Bit ALL_BIT is driven 0, and cmd_ba is the bank.
- R5: A RD or WR to an idle bank, or to a bank that is still counting down, issues NOP and pulses req_err high for exactly one cycle.
- R6: A PRE with req_all=0 drives 0010, with cmd_addr[ALL_BIT]=0 and cmd_ba set to req_bank. That bank becomes idle.
- R7: A PRE with req_all=1 drives 0010, with only cmd_addr[ALL_BIT] set and cmd_ba=0 whatever req_bank holds. Every bank becomes idle.
- R8: After a PRE sampled on clock edge k, an ACT to a bank that PRE closed is accepted only at edge k+T_RP or later. An earlier ACT to that bank gives NOP and req_err.
- R9: An ACT to a bank that is already open gives NOP and req_err.
- R10: A PRE to a bank that is already idle is issued normally and restarts that bank's countdown.
- R11: all_idle is 1 only when every bank is idle and every countdown has expired.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | A request is present this cycle |
| req_op | input | 2 | Request opcode: ACT=0, RD=1, WR=2, PRE=3 |
| req_bank | input | BA_W | Target bank |
| req_all | input | 1 | For PRE, close every bank |
| req_arg | input | ADDR_W | Row for ACT; column in the low COL_W bits for RD/WR |
| req_err | output | 1 | One-cycle pulse when a request is rejected |
| cmd_cs_n | output | 1 | Chip select, active low |
| cmd_ras_n | output | 1 | Row strobe, active low |
| cmd_cas_n | output | 1 | Column strobe, active low |
| cmd_we_n | output | 1 | Write enable, active low |
| cmd_ba | output | BA_W | Bank address pins |
| cmd_addr | output | ADDR_W | Address pins |
| bank_idle | output | NUM_BANKS | Per-bank idle flag |
| all_idle | output | 1 | Every bank idle and recovered |

## Verification
The properties assume one request at most per cycle. They also assume req_op, req_bank and req_all hold known values whenever req_valid is high, so that a past bank index always names a real bank. The stimulus holds inputs steady across each rising edge and changes them only on falling edges. It deliberately sends illegal requests, such as a read to an idle bank, an activate to an open bank, and an activate inside the recovery window. Each of these is checked against the error pulse rather than against any assumption.

// File: rtl/bst_pkg.sv
package bst_pkg;

   typedef enum logic [1:0] {
      OP_ACT = 2'd0,
      OP_RD  = 2'd1,
      OP_WR  = 2'd2,
      OP_PRE = 2'd3
   } bst_op_e;

   typedef enum logic [2:0] {
      K_NOP,
      K_ACT,
      K_RD,
      K_WR,
      K_PRE
   } bst_kind_e;

   // Pin order: {cs_n, ras_n, cas_n, we_n}
   localparam logic [3:0] PINS_NOP = 4'b0111;
   localparam logic [3:0] PINS_ACT = 4'b0011;
   localparam logic [3:0] PINS_RD  = 4'b0101;
   localparam logic [3:0] PINS_WR  = 4'b0100;
   localparam logic [3:0] PINS_PRE = 4'b0010;

endpackage

// File: rtl/bst_bank.sv
module bst_bank #(
   parameter int T_RP  = 3,
   parameter int CNT_W = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic open_i,
   input  logic close_i,
   output logic open_o,
   output logic ready_o
);

   logic             row_open;
   logic [CNT_W-1:0] rp_cnt;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         row_open <= 1'b0;
         rp_cnt   <= '0;
      end else if (close_i) begin
         row_open <= 1'b0;
         rp_cnt   <= CNT_W'(T_RP - 1);
      end else begin
         if (open_i) begin
            row_open <= 1'b1;
         end
         if (rp_cnt != '0) begin
            rp_cnt <= rp_cnt - 1'b1;
         end
      end
   end

   assign open_o  = row_open;
   assign ready_o = (rp_cnt == '0);

endmodule

// File: rtl/bst_req_check.sv
module bst_req_check
   import bst_pkg::*;
#(
   parameter int NUM_BANKS = 4,
   parameter int BA_W      = 2
) (
   input  logic                 valid_i,
   input  bst_op_e              op_i,
   input  logic [BA_W-1:0]      bank_i,
   input  logic                 all_i,
   input  logic [NUM_BANKS-1:0] open_v,
   input  logic [NUM_BANKS-1:0] ready_v,
   output bst_kind_e            kind_o,
   output logic                 err_o,
   output logic [NUM_BANKS-1:0] open_mask,
   output logic [NUM_BANKS-1:0] close_mask
);

   logic [NUM_BANKS-1:0] sel;

   always_comb begin
      sel = '0;
      sel[bank_i] = 1'b1;
   end

   always_comb begin
      kind_o     = K_NOP;
      err_o      = 1'b0;
      open_mask  = '0;
      close_mask = '0;
      if (valid_i) begin
         case (op_i)
            OP_ACT: begin
               if (!open_v[bank_i] && ready_v[bank_i]) begin
                  kind_o    = K_ACT;
                  open_mask = sel;
               end else begin
                  err_o = 1'b1;
               end
            end
            OP_RD, OP_WR: begin
               if (open_v[bank_i]) begin
                  kind_o = (op_i == OP_RD) ? K_RD : K_WR;
               end else begin
                  err_o = 1'b1;
               end
            end
            default: begin
               kind_o     = K_PRE;
               close_mask = all_i ? '1 : sel;
            end
         endcase
      end
   end

endmodule

// File: rtl/bst_cmd_encode.sv
module bst_cmd_encode
   import bst_pkg::*;
(
   input  bst_kind_e  kind_i,
   output logic [3:0] pins_o
);

   always_comb begin
      case (kind_i)
         K_ACT:   pins_o = PINS_ACT;
         K_RD:    pins_o = PINS_RD;
         K_WR:    pins_o = PINS_WR;
         K_PRE:   pins_o = PINS_PRE;
         default: pins_o = PINS_NOP;
      endcase
   end

endmodule

// File: rtl/bst_addr_mux.sv
module bst_addr_mux
   import bst_pkg::*;
#(
   parameter int ADDR_W  = 12,
   parameter int COL_W   = 10,
   parameter int ALL_BIT = 10,
   parameter int BA_W    = 2
) (
   input  bst_kind_e         kind_i,
   input  logic              all_i,
   input  logic [BA_W-1:0]   bank_i,
   input  logic [ADDR_W-1:0] arg_i,
   output logic [BA_W-1:0]   ba_o,
   output logic [ADDR_W-1:0] addr_o
);

   localparam logic [ADDR_W-1:0] ALL_MASK = ADDR_W'(1) << ALL_BIT;

   logic [COL_W-1:0]  col;
   logic [ADDR_W-1:0] col_spread;

   assign col = arg_i[COL_W-1:0];

   for (genvar i = 0; i < ADDR_W; i++) begin : g_spread
      if (i < ALL_BIT && i < COL_W) begin : g_low
         assign col_spread[i] = col[i];
      end else if (i > ALL_BIT && (i - 1) < COL_W) begin : g_high
         assign col_spread[i] = col[i-1];
      end else begin : g_zero
         assign col_spread[i] = 1'b0;
      end
   end

   always_comb begin
      ba_o   = '0;
      addr_o = '0;
      case (kind_i)
         K_ACT: begin
            ba_o   = bank_i;
            addr_o = arg_i;
         end
         K_RD, K_WR: begin
            ba_o   = bank_i;
            addr_o = col_spread;
         end
         K_PRE: begin
            ba_o   = all_i ? '0 : bank_i;
            addr_o = all_i ? ALL_MASK : '0;
         end
         default: begin
            ba_o   = '0;
            addr_o = '0;
         end
      endcase
   end

endmodule

// File: rtl/bank_state_tracker.sv
module bank_state_tracker
   import bst_pkg::*;
#(
   parameter int NUM_BANKS = 4,
   parameter int ADDR_W    = 12,
   parameter int COL_W     = 10,
   parameter int ALL_BIT   = 10,
   parameter int T_RP      = 3,
   parameter int BA_W      = $clog2(NUM_BANKS)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 req_valid,
   input  logic [1:0]           req_op,
   input  logic [BA_W-1:0]      req_bank,
   input  logic                 req_all,
   input  logic [ADDR_W-1:0]    req_arg,
   output logic                 req_err,
   output logic                 cmd_cs_n,
   output logic                 cmd_ras_n,
   output logic                 cmd_cas_n,
   output logic                 cmd_we_n,
   output logic [BA_W-1:0]      cmd_ba,
   output logic [ADDR_W-1:0]    cmd_addr,
   output logic [NUM_BANKS-1:0] bank_idle,
   output logic                 all_idle
);

   localparam int CNT_W = $clog2(T_RP + 1);

   if (NUM_BANKS < 2 || (1 << BA_W) != NUM_BANKS) begin : g_bad_banks
      $error("NUM_BANKS must be a power of two, at least 2");
   end
   if (T_RP < 1) begin : g_bad_trp
      $error("T_RP must be at least 1");
   end
   if (ALL_BIT >= ADDR_W) begin : g_bad_allbit
      $error("ALL_BIT must lie inside the address");
   end
   if (COL_W > ADDR_W - 1) begin : g_bad_col
      $error("COL_W must leave room for the all-bank bit");
   end

   logic [NUM_BANKS-1:0] open_v;
   logic [NUM_BANKS-1:0] ready_v;
   logic [NUM_BANKS-1:0] open_mask;
   logic [NUM_BANKS-1:0] close_mask;
   bst_kind_e            kind;
   logic                 err_d;
   logic [3:0]           pins_d;
   logic [BA_W-1:0]      ba_d;
   logic [ADDR_W-1:0]    addr_d;

   bst_req_check #(
      .NUM_BANKS (NUM_BANKS),
      .BA_W      (BA_W)
   ) u_check (
      .valid_i    (req_valid),
      .op_i       (bst_op_e'(req_op)),
      .bank_i     (req_bank),
      .all_i      (req_all),
      .open_v     (open_v),
      .ready_v    (ready_v),
      .kind_o     (kind),
      .err_o      (err_d),
      .open_mask  (open_mask),
      .close_mask (close_mask)
   );

   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      bst_bank #(
         .T_RP  (T_RP),
         .CNT_W (CNT_W)
      ) u_bank (
         .clk     (clk),
         .rst_n   (rst_n),
         .open_i  (open_mask[b]),
         .close_i (close_mask[b]),
         .open_o  (open_v[b]),
         .ready_o (ready_v[b])
      );
   end

   bst_cmd_encode u_enc (
      .kind_i (kind),
      .pins_o (pins_d)
   );

   bst_addr_mux #(
      .ADDR_W  (ADDR_W),
      .COL_W   (COL_W),
      .ALL_BIT (ALL_BIT),
      .BA_W    (BA_W)
   ) u_addr (
      .kind_i (kind),
      .all_i  (req_all),
      .bank_i (req_bank),
      .arg_i  (req_arg),
      .ba_o   (ba_d),
      .addr_o (addr_d)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         {cmd_cs_n, cmd_ras_n, cmd_cas_n, cmd_we_n} <= PINS_NOP;
         cmd_ba   <= '0;
         cmd_addr <= '0;
         req_err  <= 1'b0;
      end else begin
         {cmd_cs_n, cmd_ras_n, cmd_cas_n, cmd_we_n} <= pins_d;
         cmd_ba   <= ba_d;
         cmd_addr <= addr_d;
         req_err  <= err_d;
      end
   end

   assign bank_idle = ~open_v;
   assign all_idle  = (&bank_idle) & (&ready_v);

endmodule

// File: rtl/bst_checker.sv
module bst_checker
   import bst_pkg::*;
#(
   parameter int NUM_BANKS = 4,
   parameter int ADDR_W    = 12,
   parameter int COL_W     = 10,
   parameter int ALL_BIT   = 10,
   parameter int T_RP      = 3,
   parameter int BA_W      = 2
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 req_valid,
   input logic [1:0]           req_op,
   input logic [BA_W-1:0]      req_bank,
   input logic                 req_all,
   input logic [ADDR_W-1:0]    req_arg,
   input logic                 req_err,
   input logic                 cmd_cs_n,
   input logic                 cmd_ras_n,
   input logic                 cmd_cas_n,
   input logic                 cmd_we_n,
   input logic [BA_W-1:0]      cmd_ba,
   input logic [ADDR_W-1:0]    cmd_addr,
   input logic [NUM_BANKS-1:0] bank_idle,
   input logic                 all_idle
);

   logic [3:0] pins;
   assign pins = {cmd_cs_n, cmd_ras_n, cmd_cas_n, cmd_we_n};

   // R2
   idle_nop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> (pins == PINS_NOP && cmd_addr == '0 && cmd_ba == '0));

   // R5
   rdwr_closed_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && (req_op == OP_RD || req_op == OP_WR) && bank_idle[req_bank])
      |=> (req_err && pins == PINS_NOP));

   // R5
   err_is_nop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_err |-> pins == PINS_NOP);

   // R6
   single_pre_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_op == OP_PRE && !req_all)
      |=> (pins == PINS_PRE && !cmd_addr[ALL_BIT] && cmd_ba == $past(req_bank)
           && bank_idle[$past(req_bank)]));

   // R7
   all_pre_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_op == OP_PRE && req_all)
      |=> (pins == PINS_PRE && cmd_addr[ALL_BIT] && cmd_ba == '0 && (&bank_idle)));

   // R9
   act_open_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_op == OP_ACT && !bank_idle[req_bank]) |=> req_err);

   // R11
   all_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      all_idle |-> (&bank_idle));

endmodule

bind bank_state_tracker bst_checker #(
   .NUM_BANKS (NUM_BANKS),
   .ADDR_W    (ADDR_W),
   .COL_W     (COL_W),
   .ALL_BIT   (ALL_BIT),
   .T_RP      (T_RP),
   .BA_W      (BA_W)
) u_bst_checker (.*);

// File: tb/bank_state_tracker_bench.sv
module bank_state_tracker_bench;

   localparam int CLK_PERIOD = 10;
   localparam int NB = 4;
   localparam int AW = 12;
   localparam int BW = 2;
   localparam int NVEC = 20;

   typedef struct packed {
      logic        v;
      logic [1:0]  op;
      logic [1:0]  bank;
      logic        all;
      logic [11:0] arg;
      logic        e_err;
      logic [3:0]  e_cmd;
      logic [1:0]  e_ba;
      logic [11:0] e_addr;
      logic [3:0]  e_idle;
      logic        e_all;
      logic [7:0]  rq;
   } vec_t;

   // ops: ACT=0 RD=1 WR=2 PRE=3; cmd {cs,ras,cas,we}: NOP 7, ACT 3, RD 5, WR 4, PRE 2
   localparam vec_t TBL [NVEC] = '{
      '{1'b0, 2'd0, 2'd0, 1'b0, 12'h000, 1'b0, 4'h7, 2'd0, 12'h000, 4'hF, 1'b1, 8'd2},  // R2
      '{1'b1, 2'd1, 2'd0, 1'b0, 12'h000, 1'b1, 4'h7, 2'd0, 12'h000, 4'hF, 1'b1, 8'd5},  // R5
      '{1'b1, 2'd0, 2'd1, 1'b0, 12'h123, 1'b0, 4'h3, 2'd1, 12'h123, 4'hD, 1'b0, 8'd3},  // R3
      '{1'b1, 2'd2, 2'd1, 1'b0, 12'h055, 1'b0, 4'h4, 2'd1, 12'h055, 4'hD, 1'b0, 8'd4},  // R4
      '{1'b1, 2'd1, 2'd1, 1'b0, 12'hFFF, 1'b0, 4'h5, 2'd1, 12'h3FF, 4'hD, 1'b0, 8'd4},  // R4
      '{1'b1, 2'd0, 2'd1, 1'b0, 12'h111, 1'b1, 4'h7, 2'd0, 12'h000, 4'hD, 1'b0, 8'd9},  // R9
      '{1'b1, 2'd3, 2'd1, 1'b0, 12'h000, 1'b0, 4'h2, 2'd1, 12'h000, 4'hF, 1'b0, 8'd6},  // R6
      '{1'b1, 2'd0, 2'd1, 1'b0, 12'h0AA, 1'b1, 4'h7, 2'd0, 12'h000, 4'hF, 1'b0, 8'd8},  // R8
      '{1'b1, 2'd0, 2'd1, 1'b0, 12'h0AA, 1'b1, 4'h7, 2'd0, 12'h000, 4'hF, 1'b1, 8'd8},  // R8
      '{1'b1, 2'd0, 2'd1, 1'b0, 12'h0AA, 1'b0, 4'h3, 2'd1, 12'h0AA, 4'hD, 1'b0, 8'd8},  // R8
      '{1'b1, 2'd0, 2'd2, 1'b0, 12'hFFF, 1'b0, 4'h3, 2'd2, 12'hFFF, 4'h9, 1'b0, 8'd3},  // R3
      '{1'b1, 2'd1, 2'd3, 1'b0, 12'h000, 1'b1, 4'h7, 2'd0, 12'h000, 4'h9, 1'b0, 8'd5},  // R5
      '{1'b1, 2'd3, 2'd3, 1'b1, 12'h5A5, 1'b0, 4'h2, 2'd0, 12'h400, 4'hF, 1'b0, 8'd7},  // R7
      '{1'b0, 2'd0, 2'd0, 1'b0, 12'h000, 1'b0, 4'h7, 2'd0, 12'h000, 4'hF, 1'b0, 8'd11}, // R11
      '{1'b1, 2'd2, 2'd2, 1'b0, 12'h000, 1'b1, 4'h7, 2'd0, 12'h000, 4'hF, 1'b1, 8'd5},  // R5
      '{1'b1, 2'd3, 2'd0, 1'b0, 12'h000, 1'b0, 4'h2, 2'd0, 12'h000, 4'hF, 1'b0, 8'd10}, // R10
      '{1'b1, 2'd0, 2'd0, 1'b0, 12'h002, 1'b1, 4'h7, 2'd0, 12'h000, 4'hF, 1'b0, 8'd10}, // R10
      '{1'b1, 2'd0, 2'd3, 1'b0, 12'h001, 1'b0, 4'h3, 2'd3, 12'h001, 4'h7, 1'b0, 8'd3},  // R3
      '{1'b0, 2'd0, 2'd0, 1'b0, 12'h000, 1'b0, 4'h7, 2'd0, 12'h000, 4'h7, 1'b0, 8'd2},  // R2
      '{1'b1, 2'd0, 2'd0, 1'b0, 12'h002, 1'b0, 4'h3, 2'd0, 12'h002, 4'h6, 1'b0, 8'd8}   // R8
   };

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_valid = 1'b0;
   logic [1:0]    req_op = 2'd0;
   logic [BW-1:0] req_bank = '0;
   logic          req_all = 1'b0;
   logic [AW-1:0] req_arg = '0;
   logic          req_err;
   logic          cmd_cs_n, cmd_ras_n, cmd_cas_n, cmd_we_n;
   logic [BW-1:0] cmd_ba;
   logic [AW-1:0] cmd_addr;
   logic [NB-1:0] bank_idle;
   logic          all_idle;

   int  total = 0;
   int  bad = 0;
   bit  done = 1'b0;

   bank_state_tracker u_bank_state_tracker (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_valid (req_valid),
      .req_op    (req_op),
      .req_bank  (req_bank),
      .req_all   (req_all),
      .req_arg   (req_arg),
      .req_err   (req_err),
      .cmd_cs_n  (cmd_cs_n),
      .cmd_ras_n (cmd_ras_n),
      .cmd_cas_n (cmd_cas_n),
      .cmd_we_n  (cmd_we_n),
      .cmd_ba    (cmd_ba),
      .cmd_addr  (cmd_addr),
      .bank_idle (bank_idle),
      .all_idle  (all_idle)
   );

   always #(CLK_PERIOD / 2) clk = ~clk;

   task automatic drive(input logic v, input logic [1:0] op, input logic [1:0] bank,
                        input logic all, input logic [11:0] arg);
      req_valid = v;
      req_op    = op;
      req_bank  = bank;
      req_all   = all;
      req_arg   = arg;
   endtask

   // observed word: {err, cmd[3:0], ba[1:0], addr[11:0], idle[3:0], all}
   task automatic check(input int rq, input string what, input logic e_err,
                        input logic [3:0] e_cmd, input logic [1:0] e_ba,
                        input logic [11:0] e_addr, input logic [3:0] e_idle,
                        input logic e_all);
      logic [23:0] got, exp;
      got = {req_err, cmd_cs_n, cmd_ras_n, cmd_cas_n, cmd_we_n, cmd_ba, cmd_addr,
             bank_idle, all_idle};
      exp = {e_err, e_cmd, e_ba, e_addr, e_idle, e_all};
      total++;
      if (got !== exp) begin
         bad++;
         $display("FAIL R%0d %s: got %h expected %h", rq, what, got, exp);
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset state
      check(1, "reset state", 1'b0, 4'h7, 2'd0, 12'h000, 4'hF, 1'b1);
      rst_n = 1'b1;
      @(negedge clk);
      check(1, "first cycle after reset", 1'b0, 4'h7, 2'd0, 12'h000, 4'hF, 1'b1);

      for (int i = 0; i < NVEC; i++) begin
         drive(TBL[i].v, TBL[i].op, TBL[i].bank, TBL[i].all, TBL[i].arg);
         @(negedge clk);
         check(int'(TBL[i].rq), $sformatf("vector %0d", i), TBL[i].e_err, TBL[i].e_cmd,
               TBL[i].e_ba, TBL[i].e_addr, TBL[i].e_idle, TBL[i].e_all);
      end

      // R1: reset in mid-run with banks open and a read pending
      drive(1'b1, 2'd1, 2'd0, 1'b0, 12'h010);
      rst_n = 1'b0;
      @(negedge clk);
      check(1, "reset mid-run", 1'b0, 4'h7, 2'd0, 12'h000, 4'hF, 1'b1);
      rst_n = 1'b1;

      // R5: bank 0 was open before reset; now idle, so read rejected
      drive(1'b1, 2'd1, 2'd0, 1'b0, 12'h010);
      @(negedge clk);
      check(5, "read after reset", 1'b1, 4'h7, 2'd0, 12'h000, 4'hF, 1'b1);

      // R3: open bank 2
      drive(1'b1, 2'd0, 2'd2, 1'b0, 12'h7E1);
      @(negedge clk);
      check(3, "activate bank 2", 1'b0, 4'h3, 2'd2, 12'h7E1, 4'hB, 1'b0);

      // R7: all-bank precharge with bank field 2 still drives ba 0
      drive(1'b1, 2'd3, 2'd2, 1'b1, 12'h000);
      @(negedge clk);
      check(7, "precharge all", 1'b0, 4'h2, 2'd0, 12'h400, 4'hF, 1'b0);

      // R11: idle but countdown running
      drive(1'b0, 2'd0, 2'd0, 1'b0, 12'h000);
      @(negedge clk);
      check(11, "all idle waits for countdown", 1'b0, 4'h7, 2'd0, 12'h000, 4'hF, 1'b0);

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (2000) @(posedge clk);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule